// File: doc/BRIEF.md
# Standard Event Status Reporting Unit

This block holds the event-status state of an instrument's command interface. It has an event register whose bits latch when events occur, an enable mask that picks which latched events count, and a summary bit that drives bit 5 of the instrument's status byte. A command decoder upstream gives it one-cycle strobes for these actions: write the mask, read the mask, read the event register, arm operation-complete, and query operation-complete. A busy flag from the output stage reports that earlier commands or an output-level change have not yet finished. Parser and device error logic send one-cycle pulses that latch their own event bits.

Reading the event register also clears it. Two kinds of request wait on the busy flag. An operation-complete arm request does not hold up any later command. It only delays setting event bit 0 until the busy flag drops. An operation-complete query blocks later commands through a command-inhibit output. When the busy flag drops, the query places the value 1 into a one-entry response slot. A downstream output queue takes that entry with a valid/ready handshake.

Top module: `ses_status_unit`

## Requirements
- R1: `sum_o` is the OR over every bit position where both the event register and the enable mask hold 1. It represents status byte bit 5 and follows the register and the mask combinationally. A new mask written with `wr_mask_i` takes effect at the next clock edge.
- R2: While `rd_mask_i` is high, `mask_rdata_o` shows the stored mask, and `mask_rdata_o` is 0 otherwise. A mask read changes neither the mask nor the event register.
- R3: While `rd_evt_i` is high, `evt_rdata_o` shows the current event register, and `evt_rdata_o` is 0 otherwise. At the clock edge that ends a read, the register clears to zero.
- R4: An `opc_cmd_i` strobe arms the operation-complete flag from the next clock edge. Event bit 0 is set at the first later clock edge where the flag is armed and `busy_i` is low. Bit 0 never rises at an edge where `busy_i` was high.
- R5: An `opc_cmd_i` strobe never asserts `inhibit_o`.
- R6: After an `opc_cmd_i` strobe, an event read returns bit 0 as 0 while `busy_i` stays high. Once the work has finished, a read returns bit 0 as 1.
- R7: An `opc_qry_i` strobe raises `inhibit_o` from the next clock edge. `inhibit_o` stays high until a clock edge where `busy_i` is low and the response slot can accept data. At that edge the slot is loaded with data 8'h01 and `inhibit_o` falls.
- R8: A `parse_err_i` pulse sets event bit 5, and a `dev_err_i` pulse sets event bit 3, each at the next clock edge. A bit holds 1 while an event is latched and 0 when clear. A mask bit of 1 means enabled.
- R9: When an event pulse arrives in the same cycle as an event read, the read returns the old contents and the new bit is present after the clear.
- R10: While reset is high and after it is released, the event register, the mask and both armed flags are zero, `oq_valid_o` is low and `inhibit_o` is low.
- R11: While `oq_valid_o` is high and `oq_ready_i` is low, the entry and its valid flag are held. A pending query response waits and does not overwrite the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mask_i | input | 1 | Write enable-mask strobe |
| mask_wdata_i | input | 8 | New enable-mask value |
| rd_mask_i | input | 1 | Read enable-mask strobe |
| rd_evt_i | input | 1 | Read-and-clear event register strobe |
| opc_cmd_i | input | 1 | Operation-complete arm strobe |
| opc_qry_i | input | 1 | Operation-complete query strobe |
| busy_i | input | 1 | Earlier commands or output change still pending |
| parse_err_i | input | 1 | Parser error event pulse |
| dev_err_i | input | 1 | Device error event pulse |
| oq_ready_i | input | 1 | Output queue accepts the response entry |
| evt_rdata_o | output | 8 | Event register read data |
| mask_rdata_o | output | 8 | Enable-mask read data |
| sum_o | output | 1 | Summary bit for status byte bit 5 |
| oq_valid_o | output | 1 | Response entry valid |
| oq_data_o | output | 8 | Response entry value |
| inhibit_o | output | 1 | Hold off later commands |

## Verification
The assertions assume that every command and event input is a clean one-cycle strobe sampled at a clock edge. They also assume that `busy_i` changes only between edges and that nothing drives inputs during reset. The bench drives every input at the falling clock edge and returns each strobe to zero after one cycle. It changes `busy_i` only between tests or at points chosen in advance, and it holds all strobes low while reset is high. The queue back-pressure checks depend on the consumer keeping `oq_ready_i` low for several cycles, so the bench holds it low on purpose while a second query is waiting.

// File: rtl/ses_pkg.sv
package ses_pkg;

    localparam int EVT_W     = 8;
    localparam int OPC_BIT   = 0;
    localparam int DEV_BIT   = 3;
    localparam int PARSE_BIT = 5;
    localparam int SUM_POS   = 5;
    localparam int RESP_W    = 8;

    typedef logic [EVT_W-1:0]  evt_t;
    typedef logic [RESP_W-1:0] resp_t;

    localparam resp_t RESP_DONE = resp_t'(1);

    typedef struct packed {
        logic wr_mask;
        logic rd_mask;
        logic rd_evt;
        logic opc_cmd;
        logic opc_qry;
    } cmd_t;

    typedef struct packed {
        logic opc_done;
        logic dev_err;
        logic parse_err;
    } evt_src_t;

    function automatic evt_t set_vector(input evt_src_t src);
        evt_t v;
        v            = '0;
        v[OPC_BIT]   = src.opc_done;
        v[DEV_BIT]   = src.dev_err;
        v[PARSE_BIT] = src.parse_err;
        return v;
    endfunction

    function automatic logic summarize(input evt_t evt, input evt_t en);
        return |(evt & en);
    endfunction

endpackage

// File: rtl/ses_event_reg.sv
module ses_event_reg
    import ses_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  evt_t set_i,
    output evt_t evt_o
);

    evt_t evt_q;

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                evt_q[b] <= 1'b0;
            else if (set_i[b])
                evt_q[b] <= 1'b1;
            else if (clr_i)
                evt_q[b] <= 1'b0;
        end
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/ses_opc_ctrl.sv
module ses_opc_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic opc_cmd_i,
    input  logic opc_qry_i,
    input  logic busy_i,
    input  logic slot_free_i,
    output logic opc_done_o,
    output logic qry_load_o,
    output logic inhibit_o,
    output logic cmd_armed_o
);

    logic cmd_armed_q;
    logic qry_pend_q;
    logic cmd_fire;
    logic qry_fire;

    assign cmd_fire = cmd_armed_q & ~busy_i;
    assign qry_fire = qry_pend_q & ~busy_i & slot_free_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_armed_q <= 1'b0;
            qry_pend_q  <= 1'b0;
        end else begin
            cmd_armed_q <= (cmd_armed_q & ~cmd_fire) | opc_cmd_i;
            qry_pend_q  <= (qry_pend_q & ~qry_fire) | opc_qry_i;
        end
    end

    assign opc_done_o  = cmd_fire;
    assign qry_load_o  = qry_fire;
    assign inhibit_o   = qry_pend_q;
    assign cmd_armed_o = cmd_armed_q;

endmodule

// File: rtl/ses_resp_slot.sv
module ses_resp_slot
    import ses_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  resp_t data_i,
    input  logic  ready_i,
    output logic  free_o,
    output logic  valid_o,
    output resp_t data_o
);

    logic  valid_q;
    resp_t data_q;

    assign free_o = ~valid_q | ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
        end else if (valid_q && ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/ses_status_unit.sv
module ses_status_unit
    import ses_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_mask_i,
    input  logic [7:0] mask_wdata_i,
    input  logic       rd_mask_i,
    input  logic       rd_evt_i,
    input  logic       opc_cmd_i,
    input  logic       opc_qry_i,
    input  logic       busy_i,
    input  logic       parse_err_i,
    input  logic       dev_err_i,
    input  logic       oq_ready_i,
    output logic [7:0] evt_rdata_o,
    output logic [7:0] mask_rdata_o,
    output logic       sum_o,
    output logic       oq_valid_o,
    output logic [7:0] oq_data_o,
    output logic       inhibit_o
);

    cmd_t     cmd;
    evt_src_t src;
    evt_t     evt_q;
    evt_t     mask_q;
    logic     opc_done;
    logic     qry_load;
    logic     slot_free;
    logic     cmd_armed;

    assign cmd = '{wr_mask: wr_mask_i, rd_mask: rd_mask_i, rd_evt: rd_evt_i,
                   opc_cmd: opc_cmd_i, opc_qry: opc_qry_i};

    assign src = '{opc_done: opc_done, dev_err: dev_err_i, parse_err: parse_err_i};

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (cmd.wr_mask)
            mask_q <= evt_t'(mask_wdata_i);
    end

    ses_event_reg u_evt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cmd.rd_evt),
        .set_i (set_vector(src)),
        .evt_o (evt_q)
    );

    ses_opc_ctrl u_opc (
        .clk         (clk),
        .rst         (rst),
        .opc_cmd_i   (cmd.opc_cmd),
        .opc_qry_i   (cmd.opc_qry),
        .busy_i      (busy_i),
        .slot_free_i (slot_free),
        .opc_done_o  (opc_done),
        .qry_load_o  (qry_load),
        .inhibit_o   (inhibit_o),
        .cmd_armed_o (cmd_armed)
    );

    ses_resp_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .load_i  (qry_load),
        .data_i  (RESP_DONE),
        .ready_i (oq_ready_i),
        .free_o  (slot_free),
        .valid_o (oq_valid_o),
        .data_o  (oq_data_o)
    );

    assign evt_rdata_o  = cmd.rd_evt  ? evt_q  : '0;
    assign mask_rdata_o = cmd.rd_mask ? mask_q : '0;
    assign sum_o        = summarize(evt_q, mask_q);

endmodule

// File: rtl/ses_status_chk.sv
module ses_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_mask_i,
    input logic [7:0] mask_wdata_i,
    input logic       rd_evt_i,
    input logic       opc_cmd_i,
    input logic       busy_i,
    input logic       parse_err_i,
    input logic       dev_err_i,
    input logic       oq_ready_i,
    input logic [7:0] evt_q,
    input logic       sum_o,
    input logic       oq_valid_o,
    input logic [7:0] oq_data_o,
    input logic       inhibit_o
);

    // R1: an all-zero mask leaves the summary bit low
    p_zero_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_mask_i && mask_wdata_i == 8'h00) |=> !sum_o);

    // R3: a read with no new event leaves the error bits clear
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_evt_i && !parse_err_i && !dev_err_i) |=> (evt_q[7:1] == 7'd0));

    // R4: operation-complete bit rises only after an idle cycle
    p_opc_waits_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_q[0]) |-> !$past(busy_i));

    // R5: arming alone never stalls commands
    p_arm_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (opc_cmd_i && !inhibit_o) |=> !$rose(inhibit_o) || $past(inhibit_o));

    // R7: inhibit cannot clear while work is pending
    p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (inhibit_o && busy_i) |=> inhibit_o);

    // R8: event pulses land in their own bits
    p_parse_bit_r8: assert property (@(posedge clk) disable iff (rst)
        parse_err_i |=> evt_q[5]);
    p_dev_bit_r8: assert property (@(posedge clk) disable iff (rst)
        dev_err_i |=> evt_q[3]);

    // R11: an untaken entry is held unchanged
    p_slot_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (oq_valid_o && !oq_ready_i) |=> (oq_valid_o && $stable(oq_data_o)));

endmodule

bind ses_status_unit ses_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_mask_i    (wr_mask_i),
    .mask_wdata_i (mask_wdata_i),
    .rd_evt_i     (rd_evt_i),
    .opc_cmd_i    (opc_cmd_i),
    .busy_i       (busy_i),
    .parse_err_i  (parse_err_i),
    .dev_err_i    (dev_err_i),
    .oq_ready_i   (oq_ready_i),
    .evt_q        (evt_q),
    .sum_o        (sum_o),
    .oq_valid_o   (oq_valid_o),
    .oq_data_o    (oq_data_o),
    .inhibit_o    (inhibit_o)
);

// File: tb/tb_ses_status_unit.sv
`timescale 1ns/1ps
module tb_ses_status_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_mask_i = 1'b0;
    logic [7:0] mask_wdata_i = 8'h00;
    logic       rd_mask_i = 1'b0;
    logic       rd_evt_i = 1'b0;
    logic       opc_cmd_i = 1'b0;
    logic       opc_qry_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       parse_err_i = 1'b0;
    logic       dev_err_i = 1'b0;
    logic       oq_ready_i = 1'b0;
    logic [7:0] evt_rdata_o;
    logic [7:0] mask_rdata_o;
    logic       sum_o;
    logic       oq_valid_o;
    logic [7:0] oq_data_o;
    logic       inhibit_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ses_status_unit dut (
        .clk(clk), .rst(rst), .wr_mask_i(wr_mask_i), .mask_wdata_i(mask_wdata_i),
        .rd_mask_i(rd_mask_i), .rd_evt_i(rd_evt_i), .opc_cmd_i(opc_cmd_i),
        .opc_qry_i(opc_qry_i), .busy_i(busy_i), .parse_err_i(parse_err_i),
        .dev_err_i(dev_err_i), .oq_ready_i(oq_ready_i), .evt_rdata_o(evt_rdata_o),
        .mask_rdata_o(mask_rdata_o), .sum_o(sum_o), .oq_valid_o(oq_valid_o),
        .oq_data_o(oq_data_o), .inhibit_o(inhibit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read the event register: sample during the strobe, clear at the edge
    task automatic read_evt(output logic [7:0] v);
        rd_evt_i = 1'b1;
        #1 v = evt_rdata_o;
        tick();
        rd_evt_i = 1'b0;
    endtask

    task automatic write_mask(input logic [7:0] m);
        wr_mask_i = 1'b1;
        mask_wdata_i = m;
        tick();
        wr_mask_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk(inhibit_o == 1'b0, "R10 inhibit", inhibit_o, 0);
        chk(oq_valid_o == 1'b0, "R10 valid", oq_valid_o, 0);
        chk(sum_o == 1'b0, "R10 sum", sum_o, 0);
        rd_mask_i = 1'b1;
        #1 chk(mask_rdata_o == 8'h00, "R10 mask", mask_rdata_o, 0);
        rd_mask_i = 1'b0;
        read_evt(v);
        chk(v == 8'h00, "R10 evt", v, 0);
    endtask

    task automatic t_mask_rw();
        logic [7:0] v;
        write_mask(8'hA5);
        for (int i = 0; i < 3; i++) begin
            rd_mask_i = 1'b1;
            #1 chk(mask_rdata_o == 8'hA5, "R2 mask read", mask_rdata_o, 8'hA5);
            tick();
            rd_mask_i = 1'b0;
        end
        #1 chk(mask_rdata_o == 8'h00, "R2 idle read data", mask_rdata_o, 0);
        read_evt(v);
        chk(v == 8'h00, "R2 evt untouched", v, 0);
    endtask

    task automatic t_summary();
        logic [7:0] v;
        write_mask(8'h08);
        #1 chk(sum_o == 1'b0, "R1 no event", sum_o, 0);
        dev_err_i = 1'b1;
        tick();
        dev_err_i = 1'b0;
        #1 chk(sum_o == 1'b1, "R1 enabled dev bit", sum_o, 1);
        write_mask(8'h20);
        #1 chk(sum_o == 1'b0, "R1 masked dev bit", sum_o, 0);
        parse_err_i = 1'b1;
        tick();
        parse_err_i = 1'b0;
        #1 chk(sum_o == 1'b1, "R1 enabled parse bit", sum_o, 1);
        write_mask(8'h00);
        #1 chk(sum_o == 1'b0, "R1 zero mask", sum_o, 0);
        read_evt(v);
        chk(v == 8'h28, "R8 both bits", v, 8'h28);
        read_evt(v);
        chk(v == 8'h00, "R3 cleared after read", v, 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        write_mask(8'h08);
        parse_err_i = 1'b1;
        tick();
        parse_err_i = 1'b0;
        dev_err_i = 1'b1;
        read_evt(v);
        dev_err_i = 1'b0;
        chk(v == 8'h20, "R9 old contents", v, 8'h20);
        #1 chk(sum_o == 1'b1, "R9 new bit summarized", sum_o, 1);
        read_evt(v);
        chk(v == 8'h08, "R9 new bit survives", v, 8'h08);
        #1 chk(sum_o == 1'b0, "R3 sum after clear", sum_o, 0);
        write_mask(8'h00);
    endtask

    task automatic t_opc_cmd();
        logic [7:0] v;
        busy_i = 1'b1;
        opc_cmd_i = 1'b1;
        tick();
        opc_cmd_i = 1'b0;
        #1 chk(inhibit_o == 1'b0, "R5 no inhibit", inhibit_o, 0);
        tick(); tick();
        read_evt(v);
        chk(v[0] == 1'b0, "R6 busy read bit0", v[0], 0);
        chk(inhibit_o == 1'b0, "R5 still no inhibit", inhibit_o, 0);
        tick();
        busy_i = 1'b0;
        tick();
        read_evt(v);
        chk(v == 8'h01, "R4 bit0 after idle", v, 1);
        read_evt(v);
        chk(v == 8'h00, "R4 bit0 fires once", v, 0);
    endtask

    task automatic t_opc_qry();
        busy_i = 1'b1;
        oq_ready_i = 1'b0;
        opc_qry_i = 1'b1;
        tick();
        opc_qry_i = 1'b0;
        #1 chk(inhibit_o == 1'b1, "R7 inhibit raised", inhibit_o, 1);
        tick(); tick();
        chk(inhibit_o == 1'b1, "R7 inhibit while busy", inhibit_o, 1);
        chk(oq_valid_o == 1'b0, "R7 no response while busy", oq_valid_o, 0);
        busy_i = 1'b0;
        tick();
        chk(oq_valid_o == 1'b1, "R7 response valid", oq_valid_o, 1);
        chk(oq_data_o == 8'h01, "R7 response data", oq_data_o, 1);
        chk(inhibit_o == 1'b0, "R7 inhibit released", inhibit_o, 0);
        oq_ready_i = 1'b1;
        tick();
        oq_ready_i = 1'b0;
        chk(oq_valid_o == 1'b0, "R7 entry taken", oq_valid_o, 0);
    endtask

    task automatic t_backpressure();
        opc_qry_i = 1'b1;
        tick();
        opc_qry_i = 1'b0;
        tick();
        chk(oq_valid_o == 1'b1, "R11 first entry", oq_valid_o, 1);
        opc_qry_i = 1'b1;
        tick();
        opc_qry_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(oq_valid_o == 1'b1 && oq_data_o == 8'h01, "R11 entry held",
                {oq_valid_o, oq_data_o}, 9'h101);
            chk(inhibit_o == 1'b1, "R11 second query waits", inhibit_o, 1);
        end
        oq_ready_i = 1'b1;
        tick();
        chk(oq_valid_o == 1'b1, "R11 second entry loaded", oq_valid_o, 1);
        chk(inhibit_o == 1'b0, "R11 inhibit drops on load", inhibit_o, 0);
        tick();
        oq_ready_i = 1'b0;
        chk(oq_valid_o == 1'b0, "R11 drained", oq_valid_o, 0);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_summary();
        t_collision();
        t_opc_cmd();
        t_opc_qry();
        t_backpressure();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule